// File: doc/BRIEF.md
# CAN Interrupt Flag and Enable Unit

This block keeps the interrupt status of a message-buffer CAN controller. Each message buffer has a transmit-complete flag and a receive-complete flag, and the node has one state-change flag. Every flag has its own enable bit. The protocol engine sends single-cycle strobes when a buffer finishes sending, when a buffer finishes receiving, and when the node changes state. Each strobe sets the matching flag. The CPU-side transmit-request logic sends a per-buffer strobe whenever software sets a new transmit request, and that strobe clears the buffer's transmit-complete flag.

Software reaches the flags and enables through a simple register port. A write takes effect on the clock edge. A read is combinational on the read address. A flag is cleared by writing 0 to its bit, and writing 1 to a flag bit has no effect. The block drives three level interrupt requests: transmit, receive and node state. Each request is high while at least one flag of its group is set together with its enable bit.

Top module: `can_irq_unit`

## Requirements
- R1: A synchronous reset clears every flag and every enable bit, and drives all three interrupt outputs low on the next clock edge.
- R2: A `tx_done_i[i]` strobe sets transmit flag i (readable at address 0, bit i) at the next edge. No flag is ever set without its own strobe.
- R3: A `tx_req_set_i[i]` strobe clears transmit flag i at the next edge.
- R4: A write with a 0 in bit i of a flag register clears flag i. A write with a 1 in bit i leaves flag i as it was. This holds for the transmit flags (address 0), the receive flags (address 2) and the node flag (address 4, bit 0).
- R5: An `rx_done_i[i]` strobe sets receive flag i (address 2, bit i). A transmit-request strobe has no effect on the receive flags.
- R6: A `node_chg_i` strobe sets the node flag (address 4, bit 0). Address 4, bit 1 holds the node enable, which is written directly.
- R7: When a set strobe and a clearing action (a write of 0 or a transmit-request strobe) hit the same flag in the same cycle, the flag ends up set.
- R8: Each interrupt output is registered. It is high in the cycle after the edge at which its group holds at least one flag whose enable bit is 1, and it stays high while such a pair remains.
- R9: Clearing the flag or the enable bit of the only active pair drops the interrupt output one edge after the register update.
- R10: The enable registers at address 1 (transmit) and address 3 (receive) read back exactly what was last written. Reads of addresses 5 to 7 return 0, and writes to those addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | DATA_W | Combinational read data |
| tx_done_i | input | NBUF | Per-buffer transmit-complete strobes |
| rx_done_i | input | NBUF | Per-buffer receive-complete strobes |
| tx_req_set_i | input | NBUF | Per-buffer strobes for a newly set transmit request |
| node_chg_i | input | 1 | Node state-change strobe |
| irq_tx_o | output | 1 | Transmit interrupt request |
| irq_rx_o | output | 1 | Receive interrupt request |
| irq_node_o | output | 1 | Node state interrupt request |

## Verification
The bench builds the block with its defaults: eight buffers, 8-bit data and registered requests. It therefore checks the one-cycle lag from a flag-and-enable pair to its request, and every bit lane of a full-width register. With eight buffers the bench can set and clear patterns in which some lanes are enabled and others are not. It can also drive a set strobe and a clear on one lane in the same cycle while other lanes are only cleared. That way one vector covers set-wins, write-1-keeps and write-0-clears together.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
   localparam int REG_AW = 3;
   typedef enum logic [REG_AW-1:0] {
      ADR_TXFLAG = 3'd0,
      ADR_TXEN   = 3'd1,
      ADR_RXFLAG = 3'd2,
      ADR_RXEN   = 3'd3,
      ADR_NODE   = 3'd4
   } reg_adr_e;
   localparam int NODE_FLAG_BIT = 0;
   localparam int NODE_EN_BIT   = 1;
endpackage

// File: rtl/cif_flag_bank.sv
module cif_flag_bank #(
   parameter int W = 8
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic [W-1:0] hw_set_i,
   input  logic [W-1:0] hw_clr_i,
   input  logic         wr_stb_i,
   input  logic [W-1:0] wr_bits_i,
   output logic [W-1:0] flags_o
);
   if (W < 1) begin : g_bad_w
      $error("cif_flag_bank: W must be at least 1");
   end

   logic [W-1:0] sw_clr;
   assign sw_clr = wr_stb_i ? ~wr_bits_i : '0;

   always_ff @(posedge clk_i) begin
      if (rst_i) flags_o <= '0;
      else       flags_o <= hw_set_i | (flags_o & ~hw_clr_i & ~sw_clr);
   end

   // R7: a set strobe always lands, whatever clears arrive with it
   p_set_wins_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      (hw_set_i != '0) |=> ((flags_o & $past(hw_set_i)) == $past(hw_set_i)));
   // R3: a hardware clear without a set empties the bit
   p_hw_clear_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      ((hw_clr_i & ~hw_set_i) != '0) |=> ((flags_o & $past(hw_clr_i & ~hw_set_i)) == '0));
   // R4: writing 1 keeps a set flag
   p_write_one_keeps_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      wr_stb_i |=> ((flags_o & $past(flags_o & wr_bits_i & ~hw_clr_i))
                    == $past(flags_o & wr_bits_i & ~hw_clr_i)));
   // R2: no flag rises without its own strobe
   p_no_spurious_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      1'b1 |=> ((flags_o & ~$past(flags_o) & ~$past(hw_set_i)) == '0));
endmodule

// File: rtl/cif_irq_gate.sv
module cif_irq_gate #(
   parameter int W       = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic [W-1:0] flags_i,
   input  logic [W-1:0] enables_i,
   output logic         irq_o
);
   if (W < 1) begin : g_bad_w
      $error("cif_irq_gate: W must be at least 1");
   end

   logic any_live;
   assign any_live = |(flags_i & enables_i);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i) begin
         if (rst_i) irq_o <= 1'b0;
         else       irq_o <= any_live;
      end
      // R8: a live pair raises the request one edge later
      p_irq_raise_r8: assert property (@(posedge clk_i) disable iff (rst_i)
         any_live |=> irq_o);
      // R9: no live pair, request low one edge later
      p_irq_drop_r9: assert property (@(posedge clk_i) disable iff (rst_i)
         !any_live |=> !irq_o);
   end else begin : g_comb
      assign irq_o = any_live;
   end
endmodule

// File: rtl/can_irq_unit.sv
module can_irq_unit
   import can_irq_pkg::*;
#(
   parameter int NBUF    = 8,
   parameter int DATA_W  = 8,
   parameter bit REG_IRQ = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              wr_en_i,
   input  logic [2:0]        wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [2:0]        rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic [NBUF-1:0]   tx_done_i,
   input  logic [NBUF-1:0]   rx_done_i,
   input  logic [NBUF-1:0]   tx_req_set_i,
   input  logic              node_chg_i,
   output logic              irq_tx_o,
   output logic              irq_rx_o,
   output logic              irq_node_o
);
   localparam int NODE_W = NODE_EN_BIT + 1;

   if (NBUF < 1 || NBUF > DATA_W) begin : g_bad_nbuf
      $error("can_irq_unit: NBUF must lie in 1..DATA_W");
   end
   if (DATA_W < NODE_W) begin : g_bad_dw
      $error("can_irq_unit: DATA_W too narrow for node register");
   end

   logic [NBUF-1:0] tx_flag, rx_flag, tx_en, rx_en;
   logic            node_flag, node_en;
   logic            wr_txf, wr_txe, wr_rxf, wr_rxe, wr_node;

   assign wr_txf  = wr_en_i && (wr_addr_i == ADR_TXFLAG);
   assign wr_txe  = wr_en_i && (wr_addr_i == ADR_TXEN);
   assign wr_rxf  = wr_en_i && (wr_addr_i == ADR_RXFLAG);
   assign wr_rxe  = wr_en_i && (wr_addr_i == ADR_RXEN);
   assign wr_node = wr_en_i && (wr_addr_i == ADR_NODE);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         tx_en   <= '0;
         rx_en   <= '0;
         node_en <= 1'b0;
      end else begin
         if (wr_txe)  tx_en   <= wr_data_i[NBUF-1:0];
         if (wr_rxe)  rx_en   <= wr_data_i[NBUF-1:0];
         if (wr_node) node_en <= wr_data_i[NODE_EN_BIT];
      end
   end

   cif_flag_bank #(.W(NBUF)) u_txf (
      .clk_i(clk_i), .rst_i(rst_i), .hw_set_i(tx_done_i), .hw_clr_i(tx_req_set_i),
      .wr_stb_i(wr_txf), .wr_bits_i(wr_data_i[NBUF-1:0]), .flags_o(tx_flag));

   cif_flag_bank #(.W(NBUF)) u_rxf (
      .clk_i(clk_i), .rst_i(rst_i), .hw_set_i(rx_done_i), .hw_clr_i('0),
      .wr_stb_i(wr_rxf), .wr_bits_i(wr_data_i[NBUF-1:0]), .flags_o(rx_flag));

   cif_flag_bank #(.W(1)) u_ndf (
      .clk_i(clk_i), .rst_i(rst_i), .hw_set_i(node_chg_i), .hw_clr_i(1'b0),
      .wr_stb_i(wr_node), .wr_bits_i(wr_data_i[NODE_FLAG_BIT]), .flags_o(node_flag));

   cif_irq_gate #(.W(NBUF), .REG_OUT(REG_IRQ)) u_gtx (
      .clk_i(clk_i), .rst_i(rst_i), .flags_i(tx_flag), .enables_i(tx_en), .irq_o(irq_tx_o));
   cif_irq_gate #(.W(NBUF), .REG_OUT(REG_IRQ)) u_grx (
      .clk_i(clk_i), .rst_i(rst_i), .flags_i(rx_flag), .enables_i(rx_en), .irq_o(irq_rx_o));
   cif_irq_gate #(.W(1), .REG_OUT(REG_IRQ)) u_gnd (
      .clk_i(clk_i), .rst_i(rst_i), .flags_i(node_flag), .enables_i(node_en), .irq_o(irq_node_o));

   always_comb begin
      rd_data_o = '0;
      case (rd_addr_i)
         ADR_TXFLAG: rd_data_o[NBUF-1:0] = tx_flag;
         ADR_TXEN:   rd_data_o[NBUF-1:0] = tx_en;
         ADR_RXFLAG: rd_data_o[NBUF-1:0] = rx_flag;
         ADR_RXEN:   rd_data_o[NBUF-1:0] = rx_en;
         ADR_NODE: begin
            rd_data_o[NODE_FLAG_BIT] = node_flag;
            rd_data_o[NODE_EN_BIT]   = node_en;
         end
         default:    rd_data_o = '0;
      endcase
   end

   // R1: reset leaves every request low
   p_reset_quiet_r1: assert property (@(posedge clk_i)
      rst_i |=> (!irq_tx_o && !irq_rx_o && !irq_node_o));
   // R5: a transmit request never touches receive flags
   p_rx_untouched_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      (!wr_rxf && rx_done_i == '0) |=> (rx_flag == $past(rx_flag)));
endmodule

// File: tb/test_can_irq_unit.sv
`timescale 1ns/100ps
module test_can_irq_unit;
   localparam int NB = 8;
   localparam int DW = 8;
   localparam int NV = 19;

   logic clk = 1'b0, rst = 1'b1;
   logic wr_en = 1'b0;
   logic [2:0] wr_addr = '0, rd_addr = '0;
   logic [DW-1:0] wr_data = '0, rd_data;
   logic [NB-1:0] txd = '0, rxd = '0, treq = '0;
   logic nev = 1'b0;
   logic itx, irx, ind;

   int n_chk = 0, n_bad = 0;

   always #4 clk = ~clk;

   can_irq_unit i_can_irq_unit (
      .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .rd_addr_i(rd_addr), .rd_data_o(rd_data), .tx_done_i(txd), .rx_done_i(rxd),
      .tx_req_set_i(treq), .node_chg_i(nev), .irq_tx_o(itx), .irq_rx_o(irx), .irq_node_o(ind));

   // vector: {we, addr, wdata, tx_done, rx_done, treq, node}
   localparam logic [36:0] VEC [NV] = '{
      {1'b1,3'd1,8'hFF,8'h00,8'h00,8'h00,1'b0}, // R10 tx enables
      {1'b1,3'd3,8'h0F,8'h00,8'h00,8'h00,1'b0}, // R10 rx enables
      {1'b1,3'd4,8'h02,8'h00,8'h00,8'h00,1'b0}, // R6 node enable
      {1'b0,3'd0,8'h00,8'h05,8'h00,8'h00,1'b0}, // R2 tx set
      {1'b0,3'd0,8'h00,8'h00,8'h00,8'h00,1'b0}, // R8 irq up
      {1'b0,3'd0,8'h00,8'h00,8'h00,8'h01,1'b0}, // R3 treq clear
      {1'b1,3'd0,8'hFB,8'h00,8'h00,8'h00,1'b0}, // R4 write 0 clears bit2
      {1'b0,3'd0,8'h00,8'h00,8'h81,8'h81,1'b0}, // R5 rx set, treq ignored by rx
      {1'b0,3'd0,8'h00,8'h00,8'h00,8'h00,1'b0}, // R8 rx irq
      {1'b1,3'd2,8'h7F,8'h00,8'h00,8'h00,1'b0}, // R4 rx write-1 keeps bit0
      {1'b1,3'd3,8'h00,8'h00,8'h00,8'h00,1'b0}, // R9 enable off
      {1'b0,3'd0,8'h00,8'h00,8'h00,8'h00,1'b1}, // R6 node set
      {1'b0,3'd0,8'h00,8'h00,8'h00,8'h00,1'b0}, // R6 node irq
      {1'b1,3'd4,8'h02,8'h00,8'h00,8'h00,1'b1}, // R7 node set vs write 0
      {1'b1,3'd0,8'h00,8'h10,8'h00,8'h00,1'b0}, // R7 tx set vs write 0
      {1'b0,3'd0,8'h00,8'h20,8'h00,8'h20,1'b0}, // R7 tx set vs treq
      {1'b1,3'd4,8'h00,8'h00,8'h00,8'h00,1'b0}, // R4 node clear, R9
      {1'b1,3'd0,8'hFF,8'h00,8'h00,8'h00,1'b0}, // R4 write ones
      {1'b1,3'd5,8'hFF,8'h00,8'h00,8'hFF,1'b0}  // R10 unmapped write
   };

   logic [NB-1:0] m_txf = '0, m_rxf = '0, m_txe = '0, m_rxe = '0;
   logic m_ndf = 1'b0, m_nde = 1'b0, m_itx = 1'b0, m_irx = 1'b0, m_ind = 1'b0;

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] m_read(input int a);
      case (a)
         0: return m_txf;
         1: return m_txe;
         2: return m_rxf;
         3: return m_rxe;
         4: return {6'b0, m_nde, m_ndf};
         default: return '0;
      endcase
   endfunction

   task automatic sweep();
      for (int a = 0; a < 6; a++) begin
         rd_addr = a[2:0];
         #0.4;
         chk($sformatf("R10 R2 R4 R5 R6 read addr %0d", a), rd_data, m_read(a));
      end
      chk("R8 R9 irq_tx", {7'b0, itx}, {7'b0, m_itx});
      chk("R8 R9 irq_rx", {7'b0, irx}, {7'b0, m_irx});
      chk("R8 R9 R6 irq_node", {7'b0, ind}, {7'b0, m_ind});
   endtask

   task automatic step(input logic [36:0] v);
      logic we; logic [2:0] ad; logic [7:0] wd;
      {we, ad, wd, txd, rxd, treq, nev} = v;
      wr_en = we; wr_addr = ad; wr_data = wd;
      @(posedge clk);
      m_itx = |(m_txf & m_txe);
      m_irx = |(m_rxf & m_rxe);
      m_ind = m_ndf & m_nde;
      m_txf = txd | (m_txf & ~treq & ~((we && ad == 0) ? ~wd : 8'h00));
      m_rxf = rxd | (m_rxf & ~((we && ad == 2) ? ~wd : 8'h00));
      m_ndf = nev | (m_ndf & !(we && ad == 4 && !wd[0]));
      if (we && ad == 1) m_txe = wd;
      if (we && ad == 3) m_rxe = wd;
      if (we && ad == 4) m_nde = wd[1];
      #1;
      wr_en = 1'b0; txd = '0; rxd = '0; treq = '0; nev = 1'b0;
      sweep();
   endtask

   initial begin : watchdog
      #100000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      sweep(); // R1 reset state
      for (int i = 0; i < NV; i++) step(VEC[i]);
      // R1: reset while flags, enables and requests are live
      step({1'b1,3'd1,8'hFF,8'h00,8'h00,8'h00,1'b0});
      step({1'b0,3'd0,8'h00,8'hFF,8'hFF,8'h00,1'b1});
      step({1'b0,3'd0,8'h00,8'h00,8'h00,8'h00,1'b0});
      chk("R1 irq_tx live before reset", {7'b0, itx}, 8'h01);
      rst = 1'b1;
      @(posedge clk);
      #1 rst = 1'b0;
      m_txf = '0; m_rxf = '0; m_txe = '0; m_rxe = '0;
      m_ndf = 1'b0; m_nde = 1'b0; m_itx = 1'b0; m_irx = 1'b0; m_ind = 1'b0;
      sweep();
      // R7: set and write 0 on every lane at once
      step({1'b1,3'd2,8'h00,8'h00,8'hA5,8'h00,1'b0});
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule